// File: doc/BRIEF.md
# GPIO Pin Interrupt Event Controller

This block watches a bank of general-purpose input pins and turns configured pin activity into interrupt requests. Each pin can be set to detect a rising edge, a falling edge, a high level or a low level, in any mix. A pin with both edge selects set therefore fires on either edge. The pins are first brought into the clock domain through a two-flop synchroniser. Detected events collect in one shared raw event vector, and each pin owns bit n of that vector and of every other per-pin register.

Two interrupt request lines hang off the raw vector. Each line has its own enable mask. The mask is changed only through write-one-to-set and write-one-to-clear aliases, so software never needs a read-modify-write to touch one pin. Each line also has a masked status view, and writing ones to that view acknowledges events. Software reaches all of this through a flat word-wide register port: byte address, write strobe, write data and combinational read data. A fixed identification word sits at offset zero.

The register-port sequencing is plain decode, so no state machine is involved. The only sequencing is the per-cycle pipeline: synchroniser, event detect, raw latch and line register.

Top module: `gpio_evt_ctrl`

## Requirements
- R1: After reset every enable, every detection select and every raw event bit is zero, and both `irq_o` bits are low.
- R2: Offset 0x000 always reads 0x50600801, and writes to that offset change nothing.
- R3: The detection selects are read/write words: low-level at 0x140, high-level at 0x144, rising-edge at 0x148, falling-edge at 0x14C. Bit n applies to pin n.
- R4: Take a pin change that is first sampled at clock edge k and matches a selected edge. It sets raw bit n at edge k+2, and not earlier. The raw vector reads the same at 0x024 and at 0x028, and raw bits are never set without a detected event.
- R5: With both edge selects set, a pin detects both edges. With no select set, pin activity sets nothing.
- R6: While a pin sits at a selected active level, its raw bit is set again every cycle, so an acknowledge only takes effect once the pin has left that level.
- R7: Line 0 enables are set by writing ones at 0x034 and cleared by writing ones at 0x03C. Line 1 uses 0x038 and 0x040. Zero bits have no effect. The enable mask reads back at both of its line's alias offsets.
- R8: The masked status of line 0 at 0x02C and of line 1 at 0x030 reads raw AND that line's enables. Writing ones to either offset clears those shared raw bits, whatever the enables are. Zero bits leave raw bits unchanged.
- R9: `irq_o[l]` is a register, active high. It goes high one cycle after raw AND the enables of line l becomes non-zero, and falls one cycle after that AND becomes zero.
- R10: When a new event and a write-one acknowledge hit the same raw bit in the same cycle, the bit ends up set.
- R11: The two lines are independent: enable writes to one line do not alter the other line's enables or request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_PINS | Asynchronous pin inputs |
| reg_addr_i | input | 12 | Register byte address |
| reg_we_i | input | 1 | Write strobe, one cycle per write |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for `reg_addr_i`, combinational |
| irq_o | output | 2 | Interrupt request lines 0 and 1, active high |

## Verification
The bench aims at the acknowledge that lands in the same cycle as a fresh edge. A design that lets the acknowledge win would silently lose that edge, and the raw bit would read zero. It also holds a selected level active across an acknowledge: a design that treated levels as one-shot would clear the bit while the pin still requests service. The exact two-edge pin-to-raw latency is checked cycle by cycle, since an extra or missing synchroniser stage shifts it. Write-zero behaviour on the set, clear and acknowledge aliases is checked, along with cross-line isolation of the enables. Random pin activity is then mixed with random register writes and compared against a bench model every cycle.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

    localparam int ADDR_W    = 12;
    localparam int NUM_LINES = 2;

    localparam logic [31:0] MODULE_ID = 32'h5060_0801;

    localparam logic [ADDR_W-1:0] OFS_ID       = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_RAW0     = 12'h024;
    localparam logic [ADDR_W-1:0] OFS_RAW1     = 12'h028;
    localparam logic [ADDR_W-1:0] OFS_STAT0    = 12'h02C;
    localparam logic [ADDR_W-1:0] OFS_STAT1    = 12'h030;
    localparam logic [ADDR_W-1:0] OFS_ENSET0   = 12'h034;
    localparam logic [ADDR_W-1:0] OFS_ENSET1   = 12'h038;
    localparam logic [ADDR_W-1:0] OFS_ENCLR0   = 12'h03C;
    localparam logic [ADDR_W-1:0] OFS_ENCLR1   = 12'h040;
    localparam logic [ADDR_W-1:0] OFS_SEL_LO   = 12'h140;
    localparam logic [ADDR_W-1:0] OFS_SEL_HI   = 12'h144;
    localparam logic [ADDR_W-1:0] OFS_SEL_RISE = 12'h148;
    localparam logic [ADDR_W-1:0] OFS_SEL_FALL = 12'h14C;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_ID,
        RG_RAW0,
        RG_RAW1,
        RG_STAT0,
        RG_STAT1,
        RG_ENSET0,
        RG_ENSET1,
        RG_ENCLR0,
        RG_ENCLR1,
        RG_SEL_LO,
        RG_SEL_HI,
        RG_SEL_RISE,
        RG_SEL_FALL
    } reg_sel_e;

    function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] ofs);
        reg_sel_e r;
        case (ofs)
            OFS_ID:       r = RG_ID;
            OFS_RAW0:     r = RG_RAW0;
            OFS_RAW1:     r = RG_RAW1;
            OFS_STAT0:    r = RG_STAT0;
            OFS_STAT1:    r = RG_STAT1;
            OFS_ENSET0:   r = RG_ENSET0;
            OFS_ENSET1:   r = RG_ENSET1;
            OFS_ENCLR0:   r = RG_ENCLR0;
            OFS_ENCLR1:   r = RG_ENCLR1;
            OFS_SEL_LO:   r = RG_SEL_LO;
            OFS_SEL_HI:   r = RG_SEL_HI;
            OFS_SEL_RISE: r = RG_SEL_RISE;
            OFS_SEL_FALL: r = RG_SEL_FALL;
            default:      r = RG_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
    parameter int NUM_PINS    = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_PINS-1:0] pin_i,
    output logic [NUM_PINS-1:0] cur_o,
    output logic [NUM_PINS-1:0] prev_o
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0][NUM_PINS-1:0] stage_q;
    logic [NUM_PINS-1:0]                  prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stage_q[0] <= '0;
        end else begin
            stage_q[0] <= pin_i;
        end
    end

    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                stage_q[s] <= '0;
            end else begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    // Previous sample of the synchronised value, used for edge compare.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_q <= '0;
        end else begin
            prev_q <= stage_q[LAST];
        end
    end

    assign cur_o  = stage_q[LAST];
    assign prev_o = prev_q;

endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
    parameter int NUM_PINS = 32
) (
    input  logic [NUM_PINS-1:0] cur_i,
    input  logic [NUM_PINS-1:0] prev_i,
    input  logic [NUM_PINS-1:0] sel_lo_i,
    input  logic [NUM_PINS-1:0] sel_hi_i,
    input  logic [NUM_PINS-1:0] sel_rise_i,
    input  logic [NUM_PINS-1:0] sel_fall_i,
    output logic [NUM_PINS-1:0] evt_o
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic rise_seen;
        logic fall_seen;
        logic lvl_seen;

        assign rise_seen = sel_rise_i[p] &  cur_i[p] & ~prev_i[p];
        assign fall_seen = sel_fall_i[p] & ~cur_i[p] &  prev_i[p];
        assign lvl_seen  = (sel_hi_i[p] & cur_i[p]) | (sel_lo_i[p] & ~cur_i[p]);

        assign evt_o[p] = rise_seen | fall_seen | lvl_seen;
    end

endmodule

// File: rtl/gpio_evt_regfile.sv
module gpio_evt_regfile
    import gpio_evt_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int DATA_W   = 32
) (
    input  logic                                clk_i,
    input  logic                                rst_ni,
    input  logic [ADDR_W-1:0]                   addr_i,
    input  logic                                we_i,
    input  logic [DATA_W-1:0]                   wdata_i,
    output logic [DATA_W-1:0]                   rdata_o,
    input  logic [NUM_PINS-1:0]                 evt_i,
    output logic [NUM_PINS-1:0]                 raw_o,
    output logic [NUM_LINES-1:0][NUM_PINS-1:0]  en_o,
    output logic [NUM_PINS-1:0]                 sel_lo_o,
    output logic [NUM_PINS-1:0]                 sel_hi_o,
    output logic [NUM_PINS-1:0]                 sel_rise_o,
    output logic [NUM_PINS-1:0]                 sel_fall_o
);

    reg_sel_e            rsel;
    logic [NUM_PINS-1:0] wbits;
    logic [NUM_PINS-1:0] ack;
    logic [NUM_PINS-1:0] raw_q;
    logic [NUM_PINS-1:0] lo_q, hi_q, rise_q, fall_q;

    assign rsel  = decode_offset(addr_i);
    assign wbits = wdata_i[NUM_PINS-1:0];

    // Acknowledge through either masked-status view clears shared raw bits.
    assign ack = (we_i && (rsel == RG_STAT0 || rsel == RG_STAT1)) ? wbits : '0;

    // A fresh event outranks a same-cycle acknowledge.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            raw_q <= '0;
        end else begin
            raw_q <= (raw_q & ~ack) | evt_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lo_q   <= '0;
            hi_q   <= '0;
            rise_q <= '0;
            fall_q <= '0;
        end else if (we_i) begin
            case (rsel)
                RG_SEL_LO:   lo_q   <= wbits;
                RG_SEL_HI:   hi_q   <= wbits;
                RG_SEL_RISE: rise_q <= wbits;
                RG_SEL_FALL: fall_q <= wbits;
                default: ;
            endcase
        end
    end

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line_en
        localparam reg_sel_e SET_SEL = (l == 0) ? RG_ENSET0 : RG_ENSET1;
        localparam reg_sel_e CLR_SEL = (l == 0) ? RG_ENCLR0 : RG_ENCLR1;

        logic [NUM_PINS-1:0] en_q;

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                en_q <= '0;
            end else if (we_i && rsel == SET_SEL) begin
                en_q <= en_q | wbits;
            end else if (we_i && rsel == CLR_SEL) begin
                en_q <= en_q & ~wbits;
            end
        end

        assign en_o[l] = en_q;
    end

    always_comb begin
        case (rsel)
            RG_ID:                  rdata_o = DATA_W'(MODULE_ID);
            RG_RAW0, RG_RAW1:       rdata_o = DATA_W'(raw_q);
            RG_STAT0:               rdata_o = DATA_W'(raw_q & en_o[0]);
            RG_STAT1:               rdata_o = DATA_W'(raw_q & en_o[1]);
            RG_ENSET0, RG_ENCLR0:   rdata_o = DATA_W'(en_o[0]);
            RG_ENSET1, RG_ENCLR1:   rdata_o = DATA_W'(en_o[1]);
            RG_SEL_LO:              rdata_o = DATA_W'(lo_q);
            RG_SEL_HI:              rdata_o = DATA_W'(hi_q);
            RG_SEL_RISE:            rdata_o = DATA_W'(rise_q);
            RG_SEL_FALL:            rdata_o = DATA_W'(fall_q);
            default:                rdata_o = '0;
        endcase
    end

    assign raw_o      = raw_q;
    assign sel_lo_o   = lo_q;
    assign sel_hi_o   = hi_q;
    assign sel_rise_o = rise_q;
    assign sel_fall_o = fall_q;

endmodule

// File: rtl/gpio_evt_line.sv
module gpio_evt_line #(
    parameter int NUM_PINS = 32
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_PINS-1:0] raw_i,
    input  logic [NUM_PINS-1:0] en_i,
    output logic                irq_o
);

    logic irq_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(raw_i & en_i);
        end
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl
    import gpio_evt_pkg::*;
#(
    parameter int NUM_PINS    = 32,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_PINS-1:0]  pin_i,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    input  logic                 reg_we_i,
    input  logic [DATA_W-1:0]    reg_wdata_i,
    output logic [DATA_W-1:0]    reg_rdata_o,
    output logic [NUM_LINES-1:0] irq_o
);

    logic [NUM_PINS-1:0]                sync_cur;
    logic [NUM_PINS-1:0]                sync_prev;
    logic [NUM_PINS-1:0]                evt;
    logic [NUM_PINS-1:0]                raw;
    logic [NUM_LINES-1:0][NUM_PINS-1:0] line_en;
    logic [NUM_PINS-1:0]                sel_lo, sel_hi, sel_rise, sel_fall;

    gpio_evt_sync #(
        .NUM_PINS    (NUM_PINS),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (pin_i),
        .cur_o  (sync_cur),
        .prev_o (sync_prev)
    );

    gpio_evt_detect #(
        .NUM_PINS (NUM_PINS)
    ) u_detect (
        .cur_i      (sync_cur),
        .prev_i     (sync_prev),
        .sel_lo_i   (sel_lo),
        .sel_hi_i   (sel_hi),
        .sel_rise_i (sel_rise),
        .sel_fall_i (sel_fall),
        .evt_o      (evt)
    );

    gpio_evt_regfile #(
        .NUM_PINS (NUM_PINS),
        .DATA_W   (DATA_W)
    ) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .addr_i     (reg_addr_i),
        .we_i       (reg_we_i),
        .wdata_i    (reg_wdata_i),
        .rdata_o    (reg_rdata_o),
        .evt_i      (evt),
        .raw_o      (raw),
        .en_o       (line_en),
        .sel_lo_o   (sel_lo),
        .sel_hi_o   (sel_hi),
        .sel_rise_o (sel_rise),
        .sel_fall_o (sel_fall)
    );

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        gpio_evt_line #(
            .NUM_PINS (NUM_PINS)
        ) u_line (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .raw_i  (raw),
            .en_i   (line_en[l]),
            .irq_o  (irq_o[l])
        );
    end

endmodule

// File: rtl/gpio_evt_chk.sv
module gpio_evt_chk
    import gpio_evt_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int DATA_W   = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    addr,
    input logic                 we,
    input logic [DATA_W-1:0]    wdata,
    input logic [DATA_W-1:0]    rdata,
    input logic [NUM_LINES-1:0] irq,
    input logic [NUM_PINS-1:0]  raw,
    input logic [NUM_PINS-1:0]  en0,
    input logic [NUM_PINS-1:0]  en1,
    input logic [NUM_PINS-1:0]  evt
);

    AST_ID_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == OFS_ID) |-> (rdata == DATA_W'(MODULE_ID))); // R2

    AST_EN_SET0: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == OFS_ENSET0) |=>
        ((en0 & $past(wdata[NUM_PINS-1:0])) == $past(wdata[NUM_PINS-1:0]))); // R7

    AST_EN_CLR1: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == OFS_ENCLR1) |=>
        ((en1 & $past(wdata[NUM_PINS-1:0])) == '0)); // R7

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!we) |=> ($stable(en0) && $stable(en1))); // R11

    AST_RAW_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (raw != $past(raw)) |-> ((raw & ~$past(raw) & ~$past(evt)) == '0)); // R4

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == OFS_STAT0) |=>
        ((raw & $past(wdata[NUM_PINS-1:0]) & ~$past(evt)) == '0)); // R8

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((raw & $past(evt)) == $past(evt))); // R10

    AST_IRQ0_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq[0]) |-> $past(|(raw & en0))); // R9

    AST_IRQ1_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq[1]) |-> $past(|(raw & en1))); // R9

endmodule

bind gpio_evt_ctrl gpio_evt_chk #(
    .NUM_PINS (NUM_PINS),
    .DATA_W   (DATA_W)
) u_chk (
    .clk   (clk_i),
    .rst_n (rst_ni),
    .addr  (reg_addr_i),
    .we    (reg_we_i),
    .wdata (reg_wdata_i),
    .rdata (reg_rdata_o),
    .irq   (irq_o),
    .raw   (raw),
    .en0   (line_en[0]),
    .en1   (line_en[1]),
    .evt   (evt)
);

// File: tb/gpio_evt_ctrl_bench.sv
module gpio_evt_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins = '0;
    logic [11:0] addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk; // 50 MHz

    gpio_evt_ctrl u_gpio_evt_ctrl (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .pin_i       (pins),
        .reg_addr_i  (addr),
        .reg_we_i    (we),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    // ---------------- bench model, built from the requirements ----------
    logic [31:0] m1, m2, mp, mraw, men0, men1, mlo, mhi, mri, mfa;
    logic [1:0]  mirq;

    function automatic logic [31:0] exp_evt(input logic [31:0] c, p, lo, hi, ri, fa);
        return (lo & ~c) | (hi & c) | (ri & c & ~p) | (fa & ~c & p);
    endfunction

    function automatic logic [31:0] exp_ack(input logic w, input logic [11:0] a, input logic [31:0] d);
        return (w && (a == 12'h02C || a == 12'h030)) ? d : 32'h0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m1 <= '0; m2 <= '0; mp <= '0; mraw <= '0; men0 <= '0; men1 <= '0;
            mlo <= '0; mhi <= '0; mri <= '0; mfa <= '0; mirq <= '0;
        end else begin
            mirq <= {|(mraw & men1), |(mraw & men0)};
            mraw <= (mraw & ~exp_ack(we, addr, wdata)) | exp_evt(m2, mp, mlo, mhi, mri, mfa);
            m1 <= pins; m2 <= m1; mp <= m2;
            if (we) begin
                case (addr)
                    12'h034: men0 <= men0 | wdata;
                    12'h038: men1 <= men1 | wdata;
                    12'h03C: men0 <= men0 & ~wdata;
                    12'h040: men1 <= men1 & ~wdata;
                    12'h140: mlo <= wdata;
                    12'h144: mhi <= wdata;
                    12'h148: mri <= wdata;
                    12'h14C: mfa <= wdata;
                    default: ;
                endcase
            end
        end
    end

    // ---------------- helpers (entered and left at a falling edge) ------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rdchk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    // ---------------- stimulus ------------------------------------------
    initial begin
        void'($urandom(32'h0C0F_FEE5));
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        chk("R1 irq after reset", {30'h0, irq}, 32'h0);
        rdchk("R1 raw after reset", 12'h024, 32'h0);
        rdchk("R1 line0 enables after reset", 12'h034, 32'h0);
        rdchk("R1 rise select after reset", 12'h148, 32'h0);

        // R2 identification word
        rdchk("R2 id", 12'h000, 32'h5060_0801);
        wr(12'h000, 32'h0);
        rdchk("R2 id after write", 12'h000, 32'h5060_0801);

        // R3 select read/write
        wr(12'h140, 32'hA5A5_0F0F);
        wr(12'h144, 32'h1234_5678);
        wr(12'h148, 32'hFFFF_0000);
        wr(12'h14C, 32'h0000_FFFF);
        rdchk("R3 low select", 12'h140, 32'hA5A5_0F0F);
        rdchk("R3 high select", 12'h144, 32'h1234_5678);
        rdchk("R3 rise select", 12'h148, 32'hFFFF_0000);
        rdchk("R3 fall select", 12'h14C, 32'h0000_FFFF);
        wr(12'h140, 0); wr(12'h144, 0); wr(12'h148, 0); wr(12'h14C, 0);
        wr(12'h02C, 32'hFFFF_FFFF);
        rdchk("R8 ack all clears raw", 12'h024, 32'h0);

        // R4 rising edge latency
        wr(12'h148, 32'h0000_0008);
        pins[3] = 1'b1;
        step(2);
        rdchk("R4 raw not before edge k+2", 12'h024, 32'h0);
        step(1);
        rdchk("R4 raw at edge k+2 via 0x024", 12'h024, 32'h0000_0008);
        rdchk("R4 raw via 0x028", 12'h028, 32'h0000_0008);
        wr(12'h02C, 32'h0000_0008);
        rdchk("R8 ack clears raw", 12'h024, 32'h0);

        // R5 falling edge, both edges, no select
        wr(12'h14C, 32'h0000_0008);
        pins[3] = 1'b0;
        step(3);
        rdchk("R5 falling edge", 12'h024, 32'h0000_0008);
        wr(12'h02C, 32'h0000_0008);
        wr(12'h148, 32'h0000_0010);
        wr(12'h14C, 32'h0000_0010);
        pins[4] = 1'b1;
        step(3);
        rdchk("R5 both edges rise", 12'h024, 32'h0000_0010);
        wr(12'h030, 32'h0000_0010);
        pins[4] = 1'b0;
        step(3);
        rdchk("R5 both edges fall", 12'h024, 32'h0000_0010);
        wr(12'h02C, 32'h0000_0010);
        pins[20] = 1'b1;
        step(4);
        pins[20] = 1'b0;
        step(4);
        rdchk("R5 unselected pin sets nothing", 12'h024, 32'h0);

        // R6 level persistence
        wr(12'h144, 32'h0000_0200);
        pins[9] = 1'b1;
        step(3);
        rdchk("R6 high level sets raw", 12'h024, 32'h0000_0200);
        wr(12'h02C, 32'h0000_0200);
        rdchk("R6 ack ignored while level active", 12'h024, 32'h0000_0200);
        pins[9] = 1'b0;
        step(3);
        wr(12'h02C, 32'h0000_0200);
        rdchk("R6 ack clears once level gone", 12'h024, 32'h0);
        wr(12'h140, 32'h0000_0400);
        step(2);
        rdchk("R6 low level sets raw", 12'h024, 32'h0000_0400);
        wr(12'h140, 32'h0);
        wr(12'h02C, 32'h0000_0400);
        rdchk("R6 low level cleared", 12'h024, 32'h0);

        // R7 enable aliases, R11 independence
        wr(12'h034, 32'h0000_00F0);
        rdchk("R7 set line0", 12'h034, 32'h0000_00F0);
        wr(12'h034, 32'h0);
        rdchk("R7 set write zero no effect", 12'h034, 32'h0000_00F0);
        wr(12'h03C, 32'h0000_0030);
        rdchk("R7 clear line0 via 0x03C read", 12'h03C, 32'h0000_00C0);
        wr(12'h03C, 32'h0);
        rdchk("R7 clear write zero no effect", 12'h034, 32'h0000_00C0);
        rdchk("R11 line1 untouched", 12'h038, 32'h0);
        wr(12'h038, 32'h0000_0100);
        rdchk("R11 line0 untouched by line1 set", 12'h034, 32'h0000_00C0);
        rdchk("R7 line1 set via 0x040 read", 12'h040, 32'h0000_0100);

        // R8 masked status, R9 request timing
        wr(12'h148, 32'h0000_01C0);
        pins[6] = 1'b1;
        step(3);
        chk("R9 irq registered after raw", {30'h0, irq}, 32'h0);
        rdchk("R8 line0 masked", 12'h02C, 32'h0000_0040);
        rdchk("R8 line1 masked", 12'h030, 32'h0);
        step(1);
        chk("R9 irq0 high", {30'h0, irq}, 32'h1);
        pins[8] = 1'b1;
        step(4);
        chk("R11 both lines high", {30'h0, irq}, 32'h3);
        rdchk("R8 line1 masked pin8", 12'h030, 32'h0000_0100);
        wr(12'h030, 32'h0000_0100);
        rdchk("R8 ack via line1 clears shared raw", 12'h024, 32'h0000_0040);
        chk("R9 irq1 still registered", {30'h0, irq}, 32'h3);
        step(1);
        chk("R9 irq1 falls", {30'h0, irq}, 32'h1);
        wr(12'h030, 32'h0000_0040);
        rdchk("R8 ack ignores enables", 12'h024, 32'h0);
        step(1);
        chk("R9 irq0 falls", {30'h0, irq}, 32'h0);

        // R10 event beats acknowledge
        pins[7] = 1'b1;
        step(3);
        pins[7] = 1'b0;
        step(3);
        rdchk("R10 setup raw", 12'h024, 32'h0000_0080);
        pins[7] = 1'b1;
        step(2);
        wr(12'h02C, 32'h0000_0080);
        rdchk("R10 event wins over ack", 12'h024, 32'h0000_0080);
        wr(12'h02C, 32'h0000_0080);
        rdchk("R10 later ack clears", 12'h024, 32'h0);

        // Random phase against the model
        for (int i = 0; i < 4000; i++) begin
            int op;
            logic [31:0] v;
            pins = pins ^ ($urandom & $urandom & $urandom);
            op = $urandom % 10;
            chk("R9 random irq", {30'h0, irq}, {30'h0, mirq});
            case (op)
                0: wr(($urandom % 2) ? 12'h02C : 12'h030, $urandom);
                1: wr(($urandom % 2) ? 12'h034 : 12'h038, $urandom & $urandom);
                2: wr(($urandom % 2) ? 12'h03C : 12'h040, $urandom);
                3: wr(12'h140 + 12'(4 * ($urandom % 4)), $urandom & $urandom & $urandom);
                4: wr(12'h000, $urandom);
                default: begin
                    rd(12'h024, v);
                    chk("R4 random raw", v, mraw);
                    rd(12'h02C, v);
                    chk("R8 random masked0", v, mraw & men0);
                    rd(12'h030, v);
                    chk("R8 random masked1", v, mraw & men1);
                    step(1);
                end
            endcase
        end

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule